// File: doc/BRIEF.md
# Store-Exclusive Halfword Execution Unit

This unit carries out a conditional store-exclusive of one 16-bit halfword. A single-entry local exclusive monitor is armed by a load-exclusive request, which records a tag address. A later store-exclusive request carries three register indices, a base address, 32-bit store data and a condition-pass flag. The unit checks the operand indices and the monitor, then settles one outcome. It can write the low halfword to memory and return success status 0. It can skip the write and return status 1. It can raise an alignment fault or a data abort. It can flag an illegal operand choice, which is handled as an undefined instruction.

The unit accepts one request per cycle. Its outcome is held for one cycle in a state register, and that state drives the memory strobe, the status writeback and the fault flags. The state machine has six states:
- `ST_IDLE`: no outcome this cycle.
- `ST_COMMIT`: memory write plus status 0.
- `ST_REJECT`: status 1, no write.
- `ST_ALIGN`: alignment fault.
- `ST_ABORT`: data abort.
- `ST_UNDEF`: illegal operands.

On every edge the next state is chosen from the request in that cycle. There are six transitions:
- `go_undef`: the condition passes and the operand indices are illegal.
- `go_align`: the address is misaligned and the monitor check passes, or it fails while `FAIL_ALIGN_FAULT` is set.
- `go_abort`: the memory side signals an abort and the check passes, or it fails while `FAIL_ABORT_FAULT` is set.
- `go_commit`: the check passes and no fault applies.
- `go_reject`: the check fails and no fault is reported.
- `go_idle`: there is no request, or the condition fails.

Every state moves to whichever of these the next cycle selects.

Top module: `sthx_unit`

## Requirements
- R1: A store whose monitor check passes, with an even address and no abort, drives `mem_we` for one cycle, one cycle after the request. In that cycle `mem_addr` is the base address and `mem_wdata` is bits 15:0 of the store data. In the same cycle `wb_en` pulses with `wb_idx` equal to the status index and `wb_data` equal to 0.
- R2: A store whose monitor check fails, with no fault reported, performs no write. It pulses `wb_en` one cycle later with `wb_data` equal to 1 (bits 31:1 zero).
- R3: Every store attempt clears the monitor, whether it commits, fails or faults, provided its condition passes and its operands are legal. A second store without a new load-exclusive therefore returns 1. When a store and a load-exclusive arrive in the same cycle, the clear wins.
- R4: A data abort (`xlat_abort` high with the request) on a passing check pulses `data_abort` one cycle later, with no write and no status writeback.
- R5: An odd address (bit 0 set) on a passing check pulses `align_fault` one cycle later, with no write and no writeback. Alignment takes priority over abort.
- R6: An odd address on a failing check raises `align_fault` when `FAIL_ALIGN_FAULT`=1 (default). When the parameter is 0, the store is handled as a plain failure.
- R7: A status, data or base index equal to 15 pulses `illegal_op` one cycle later. Memory, writeback and the monitor are left unchanged.
- R8: A status index equal to the data index or to the base index is treated as R7 (undefined instruction).
- R9: When `cond_pass` is 0, the request produces no write, no writeback and no flag, and the monitor keeps its state.
- R10: `clrex` clears the monitor, so a following store fails.
- R11: `ldx_valid` arms the monitor with `ldx_addr`. The check passes only for a store to exactly that address.
- R12: Every output strobe and flag is low after reset and in any cycle not preceded by a request. At most one of `wb_en`, `align_fault`, `data_abort` and `illegal_op` is high at a time.
- R13: An abort on a failing check is reported only when `FAIL_ABORT_FAULT`=1. With the default 0 it returns status 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ldx_valid | input | 1 | Load-exclusive arms the monitor |
| ldx_addr | input | AW | Address to tag |
| clrex | input | 1 | Clear the monitor |
| st_valid | input | 1 | Store-exclusive request |
| cond_pass | input | 1 | Condition check result |
| rd_idx | input | RW | Status register index |
| rt_idx | input | RW | Data register index |
| rn_idx | input | RW | Base register index |
| base_addr | input | AW | Store address |
| st_data | input | DW | Data register value |
| xlat_abort | input | 1 | Access would abort |
| mem_we | output | 1 | Halfword write strobe |
| mem_addr | output | AW | Write address |
| mem_wdata | output | 16 | Write halfword |
| wb_en | output | 1 | Status writeback strobe |
| wb_idx | output | RW | Writeback register index |
| wb_data | output | DW | Status value |
| align_fault | output | 1 | Alignment fault |
| data_abort | output | 1 | Data abort |
| illegal_op | output | 1 | Illegal operand choice |

## Verification
A stale or wrongly kept monitor shows at the ports on the very next store. That store returns 0 and strobes memory where the model expects status 1, or the reverse, one cycle after the request. A wrong outcome state appears as a mismatched strobe or flag in the cycle straight after the request. A state that lingers shows up as a strobe in a cycle that had no request. The bench compares every output against its model on every clock, so any such error is seen within one cycle of the request that caused it.

// File: rtl/sthx_pkg.sv
package sthx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COMMIT,
        ST_REJECT,
        ST_ALIGN,
        ST_ABORT,
        ST_UNDEF
    } sthx_state_e;
endpackage

// File: rtl/sthx_opchk.sv
module sthx_opchk #(
    parameter int RW = 4
) (
    input  logic [RW-1:0] rd_idx,
    input  logic [RW-1:0] rt_idx,
    input  logic [RW-1:0] rn_idx,
    output logic          illegal
);
    localparam logic [RW-1:0] PC_IDX = {RW{1'b1}};

    logic uses_pc;
    logic overlap;

    always_comb begin
        uses_pc = (rd_idx == PC_IDX) || (rt_idx == PC_IDX) || (rn_idx == PC_IDX);
        overlap = (rd_idx == rt_idx) || (rd_idx == rn_idx);
        illegal = uses_pc || overlap;
    end
endmodule

// File: rtl/sthx_monitor.sv
module sthx_monitor #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic [AW-1:0] arm_addr,
    input  logic          clear,
    input  logic [AW-1:0] chk_addr,
    output logic          hit
);
    logic          mon_valid;
    logic [AW-1:0] mon_tag;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mon_valid <= 1'b0;
            mon_tag   <= '0;
        end else if (clear) begin
            mon_valid <= 1'b0;
        end else if (arm) begin
            mon_valid <= 1'b1;
            mon_tag   <= arm_addr;
        end
    end

    always_comb hit = mon_valid && (mon_tag == chk_addr);
endmodule

// File: rtl/sthx_fsm.sv
module sthx_fsm
    import sthx_pkg::*;
#(
    parameter bit FAIL_ALIGN_FAULT = 1'b1,
    parameter bit FAIL_ABORT_FAULT = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        illegal,
    input  logic        hit,
    input  logic        misaligned,
    input  logic        abort,
    output logic        attempt,
    output sthx_state_e state
);
    sthx_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = ST_IDLE;
        attempt  = 1'b0;
        if (req) begin
            if (illegal) begin
                state_nx = ST_UNDEF;
            end else begin
                attempt = 1'b1;
                if (misaligned && (hit || FAIL_ALIGN_FAULT))
                    state_nx = ST_ALIGN;
                else if (abort && (hit || FAIL_ABORT_FAULT))
                    state_nx = ST_ABORT;
                else if (hit)
                    state_nx = ST_COMMIT;
                else
                    state_nx = ST_REJECT;
            end
        end
    end
endmodule

// File: rtl/sthx_unit.sv
module sthx_unit
    import sthx_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int RW = 4,
    parameter bit FAIL_ALIGN_FAULT = 1'b1,
    parameter bit FAIL_ABORT_FAULT = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ldx_valid,
    input  logic [AW-1:0] ldx_addr,
    input  logic          clrex,
    input  logic          st_valid,
    input  logic          cond_pass,
    input  logic [RW-1:0] rd_idx,
    input  logic [RW-1:0] rt_idx,
    input  logic [RW-1:0] rn_idx,
    input  logic [AW-1:0] base_addr,
    input  logic [DW-1:0] st_data,
    input  logic          xlat_abort,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    output logic          wb_en,
    output logic [RW-1:0] wb_idx,
    output logic [DW-1:0] wb_data,
    output logic          align_fault,
    output logic          data_abort,
    output logic          illegal_op
);
    localparam int HW = 16;
    localparam logic [DW-1:0] STATUS_OK   = '0;
    localparam logic [DW-1:0] STATUS_FAIL = {{(DW-1){1'b0}}, 1'b1};

    logic          req;
    logic          illegal;
    logic          hit;
    logic          attempt;
    sthx_state_e   state;
    logic [AW-1:0] cap_addr;
    logic [HW-1:0] cap_data;
    logic [RW-1:0] cap_rd;

    assign req = st_valid && cond_pass;

    sthx_opchk #(.RW(RW)) u_opchk (
        .rd_idx (rd_idx),
        .rt_idx (rt_idx),
        .rn_idx (rn_idx),
        .illegal(illegal)
    );

    sthx_monitor #(.AW(AW)) u_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (ldx_valid),
        .arm_addr(ldx_addr),
        .clear   (attempt || clrex),
        .chk_addr(base_addr),
        .hit     (hit)
    );

    sthx_fsm #(
        .FAIL_ALIGN_FAULT(FAIL_ALIGN_FAULT),
        .FAIL_ABORT_FAULT(FAIL_ABORT_FAULT)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .illegal   (illegal),
        .hit       (hit),
        .misaligned(base_addr[0]),
        .abort     (xlat_abort),
        .attempt   (attempt),
        .state     (state)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_data <= '0;
            cap_rd   <= '0;
        end else if (req) begin
            cap_addr <= base_addr;
            cap_data <= st_data[HW-1:0];
            cap_rd   <= rd_idx;
        end
    end

    always_comb begin
        mem_we      = 1'b0;
        wb_en       = 1'b0;
        wb_data     = STATUS_OK;
        align_fault = 1'b0;
        data_abort  = 1'b0;
        illegal_op  = 1'b0;
        mem_addr    = cap_addr;
        mem_wdata   = cap_data;
        wb_idx      = cap_rd;
        unique case (state)
            ST_IDLE:   ;
            ST_COMMIT: begin
                mem_we  = 1'b1;
                wb_en   = 1'b1;
                wb_data = STATUS_OK;
            end
            ST_REJECT: begin
                wb_en   = 1'b1;
                wb_data = STATUS_FAIL;
            end
            ST_ALIGN:  align_fault = 1'b1;
            ST_ABORT:  data_abort  = 1'b1;
            ST_UNDEF:  illegal_op  = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/sthx_unit_checker.sv
module sthx_unit_checker #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_valid,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          wb_en,
    input logic [DW-1:0] wb_data,
    input logic          align_fault,
    input logic          data_abort,
    input logic          illegal_op
);
    a_r1_commit_status: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (wb_en && wb_data == '0));

    a_r1_even_address: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !mem_addr[0]);

    a_r2_status_form: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_data[DW-1:1] == '0));

    a_r3_no_back_to_back_commit: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    a_r4_fault_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (align_fault || data_abort || illegal_op) |-> (!mem_we && !wb_en));

    a_r12_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wb_en, align_fault, data_abort, illegal_op}));

    a_r12_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(st_valid) |-> !(wb_en || mem_we || align_fault || data_abort || illegal_op));
endmodule

bind sthx_unit sthx_unit_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_valid   (st_valid),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .wb_en      (wb_en),
    .wb_data    (wb_data),
    .align_fault(align_fault),
    .data_abort (data_abort),
    .illegal_op (illegal_op)
);

// File: tb/sthx_unit_tb.sv
module sthx_unit_tb;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int RW = 4;
    localparam bit FAIL_ALIGN = 1'b1;
    localparam bit FAIL_ABORT = 1'b0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ldx_valid = 1'b0;
    logic [AW-1:0] ldx_addr = '0;
    logic          clrex = 1'b0;
    logic          st_valid = 1'b0;
    logic          cond_pass = 1'b0;
    logic [RW-1:0] rd_idx = '0;
    logic [RW-1:0] rt_idx = '0;
    logic [RW-1:0] rn_idx = '0;
    logic [AW-1:0] base_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic          xlat_abort = 1'b0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata;
    logic          wb_en;
    logic [RW-1:0] wb_idx;
    logic [DW-1:0] wb_data;
    logic          align_fault;
    logic          data_abort;
    logic          illegal_op;

    always #2.5 clk = ~clk;

    sthx_unit #(
        .AW(AW), .DW(DW), .RW(RW),
        .FAIL_ALIGN_FAULT(FAIL_ALIGN), .FAIL_ABORT_FAULT(FAIL_ABORT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ldx_valid(ldx_valid), .ldx_addr(ldx_addr),
        .clrex(clrex), .st_valid(st_valid), .cond_pass(cond_pass),
        .rd_idx(rd_idx), .rt_idx(rt_idx), .rn_idx(rn_idx),
        .base_addr(base_addr), .st_data(st_data), .xlat_abort(xlat_abort),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
        .align_fault(align_fault), .data_abort(data_abort), .illegal_op(illegal_op)
    );

    int checks = 0;
    int failures = 0;

    // behavioural reference state
    bit            m_valid = 0;
    logic [AW-1:0] m_tag = '0;
    bit            e_we = 0, e_wb = 0, e_al = 0, e_ab = 0, e_ill = 0;
    logic [AW-1:0] e_addr = '0;
    logic [15:0]   e_wdata = '0;
    logic [RW-1:0] e_idx = '0;
    logic [DW-1:0] e_stat = '0;
    string         e_tag = "R12";

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_outputs();
        chk(e_tag, "mem_we", 64'(mem_we), 64'(e_we));
        chk(e_tag, "wb_en", 64'(wb_en), 64'(e_wb));
        chk(e_tag, "align_fault", 64'(align_fault), 64'(e_al));
        chk(e_tag, "data_abort", 64'(data_abort), 64'(e_ab));
        chk(e_tag, "illegal_op", 64'(illegal_op), 64'(e_ill));
        if (e_we) begin
            chk(e_tag, "mem_addr", 64'(mem_addr), 64'(e_addr));
            chk(e_tag, "mem_wdata", 64'(mem_wdata), 64'(e_wdata));
        end
        if (e_wb) begin
            chk(e_tag, "wb_idx", 64'(wb_idx), 64'(e_idx));
            chk(e_tag, "wb_data", 64'(wb_data), 64'(e_stat));
        end
    endtask

    // one cycle: drive at negedge, compute expectation, check after next posedge
    task automatic cyc(input string tag, input bit st, input bit cnd,
                       input int rd, input int rt, input int rn,
                       input logic [AW-1:0] addr, input logic [DW-1:0] data, input bit abt,
                       input bit ldx, input logic [AW-1:0] laddr, input bit clr);
        bit attempt, pass, ill;
        st_valid = st; cond_pass = cnd;
        rd_idx = RW'(rd); rt_idx = RW'(rt); rn_idx = RW'(rn);
        base_addr = addr; st_data = data; xlat_abort = abt;
        ldx_valid = ldx; ldx_addr = laddr; clrex = clr;
        e_we = 0; e_wb = 0; e_al = 0; e_ab = 0; e_ill = 0; e_tag = tag;
        attempt = 0;
        if (st && cnd) begin
            ill = (rd == 15) || (rt == 15) || (rn == 15) || (rd == rt) || (rd == rn);
            if (ill) e_ill = 1;
            else begin
                attempt = 1;
                pass = m_valid && (m_tag == addr);
                if (addr[0] && (pass || FAIL_ALIGN)) e_al = 1;
                else if (abt && (pass || FAIL_ABORT)) e_ab = 1;
                else if (pass) begin
                    e_we = 1; e_wb = 1; e_addr = addr; e_wdata = data[15:0];
                    e_idx = RW'(rd); e_stat = 0;
                end else begin
                    e_wb = 1; e_idx = RW'(rd); e_stat = 1;
                end
            end
        end
        if (attempt || clr) m_valid = 0;
        else if (ldx) begin m_valid = 1; m_tag = laddr; end
        @(negedge clk);
        compare_outputs();
    endtask

    task automatic idle(input string tag);
        cyc(tag, 0, 0, 0, 1, 2, '0, '0, 0, 0, '0, 0);
    endtask

    task automatic arm(input logic [AW-1:0] a);
        cyc("R11", 0, 0, 0, 1, 2, '0, '0, 0, 1, a, 0);
    endtask

    task automatic store(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] d);
        cyc(tag, 1, 1, 1, 2, 3, a, d, 0, 0, '0, 0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare_outputs();                 // R12 reset state
        rst_n = 1'b1;
        idle("R12");

        arm(32'h100);
        store("R1", 32'h100, 32'hDEAD_BEEF);    // commit
        store("R3", 32'h100, 32'h1234_5678);    // monitor cleared -> status 1
        idle("R12");

        arm(32'h200);
        store("R11", 32'h204, 32'h1111);        // tag mismatch -> fail
        store("R2", 32'h200, 32'h2222);         // already cleared -> fail

        arm(32'h300);
        cyc("R10", 0, 0, 0, 1, 2, '0, '0, 0, 0, '0, 1);
        store("R10", 32'h300, 32'h3333);

        arm(32'h301);
        store("R5", 32'h301, 32'h4444);          // pass + odd -> align fault
        store("R6", 32'h401, 32'h5555);          // fail + odd -> align fault (param)

        arm(32'h500);
        cyc("R4", 1, 1, 4, 5, 6, 32'h500, 32'h6666, 1, 0, '0, 0);
        store("R3", 32'h500, 32'h6667);          // faulting attempt cleared monitor
        cyc("R13", 1, 1, 4, 5, 6, 32'h520, 32'h7777, 1, 0, '0, 0);

        arm(32'h600);
        cyc("R7", 1, 1, 15, 2, 3, 32'h600, 32'h8888, 0, 0, '0, 0);
        cyc("R7", 1, 1, 1, 15, 3, 32'h600, 32'h8888, 0, 0, '0, 0);
        cyc("R7", 1, 1, 1, 2, 15, 32'h600, 32'h8888, 0, 0, '0, 0);
        store("R7", 32'h600, 32'h9999);          // monitor kept -> commit

        arm(32'h640);
        cyc("R8", 1, 1, 2, 2, 3, 32'h640, 32'hAAAA, 0, 0, '0, 0);
        cyc("R8", 1, 1, 3, 2, 3, 32'h640, 32'hAAAA, 0, 0, '0, 0);
        store("R8", 32'h640, 32'hBBBB);          // monitor kept -> commit

        arm(32'h700);
        cyc("R9", 1, 0, 1, 2, 3, 32'h700, 32'hCCCC, 0, 0, '0, 0);
        cyc("R9", 1, 0, 15, 15, 15, 32'h701, 32'hCCCC, 1, 0, '0, 0);
        store("R9", 32'h700, 32'hCDCD);           // still armed -> commit

        arm(32'h800);
        cyc("R3", 1, 1, 7, 8, 9, 32'h800, 32'hEEEE, 0, 1, 32'h800, 0); // clear wins over arm
        store("R3", 32'h800, 32'hEEEF);
        arm(32'h900);
        cyc("R1", 1, 1, 9, 10, 11, 32'h900, 32'hF0F0_1357, 0, 0, '0, 0);
        idle("R12");
        idle("R12");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule